// File: doc/BRIEF.md
# Circular Address Step Unit

This block computes the next value of a DSP address register that walks a circular buffer. Each cycle it takes the current address, a wrap value that sets the buffer size, a signed index and a two-bit operation code. It returns the stepped address. The operation is one of: add the index, subtract the index, step up by one, or step down by one.

Wrap-around is found from the carry pattern of the addition, not from a compare against buffer bounds. As a result, an address that leaves the power-of-two-aligned window implied by the wrap value is folded back into that window. A wrap value of all ones turns the block into plain modular arithmetic.

The stepped address is available combinationally. A parameter-selected output register adds a valid strobe and a synchronous reset.

Top module: `modstep_unit`

## Requirements
- R1: With op = 2'b00 (add) and a non-negative index, the sum ar+ix is formed. The carry pattern (sum XOR ar XOR sign-extended ix), masked by ((wrap|1)<<1), is compared with wrap. If the masked pattern is larger than wrap, wrap+1 is taken off the sum. The low 16 bits are the result.
- R2: With op = 2'b00 and a negative index, wrap+1 is added to the sum when (((sum+wrap+1) XOR sum) AND masked carry pattern) is at most wrap.
- R3: With op = 2'b01 (subtract), the difference ar-ix is formed, and its carry pattern uses the bitwise inverse of the sign-extended index. For a negative index other than -32768, wrap+1 is taken off when the masked pattern exceeds wrap.
- R4: With op = 2'b01 and an index that is zero, positive or exactly -32768, the R2-style lower-fold test is used instead.
- R5: With op = 2'b10 (increment), ar+1 is formed. Wrap+1 is taken off when ((sum XOR ar) AND ((wrap|1)<<1)) exceeds wrap.
- R6: With op = 2'b11 (decrement), ar+wrap is formed and the same fold test as R5 is applied.
- R7: With wrap = 16'hFFFF, every operation gives plain arithmetic modulo 2^16.
- R8: In increment and decrement the index input has no effect on the result.
- R9: For a nonzero wrap of the form 2^k-1, increment and decrement keep the address bits above the window (those cleared in wrap) unchanged.
- R10: With the output register enabled, out_addr and out_vld take the stepped address and in_vld one clock edge after in_vld is sampled. While in_vld is low, out_vld falls and out_addr holds.
- R11: A synchronous active-high reset clears out_addr to 16'h0000 and out_vld to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe; marks the current inputs for registering |
| op | input | 2 | 00 add, 01 subtract, 10 increment, 11 decrement |
| cur_addr | input | 16 | Current address register value |
| wrap | input | 16 | Wrap value that sets the circular window |
| step | input | 16 | Signed index, two's complement |
| nxt_addr | output | 16 | Stepped address, combinational |
| out_addr | output | 16 | Registered stepped address |
| out_vld | output | 1 | Registered strobe, high one cycle after in_vld |

## Verification
nxt_addr is due in the same cycle as its inputs. The bench drives inputs at the falling edge and samples nxt_addr one nanosecond later. out_addr and out_vld are due one rising edge later, so the bench samples them one nanosecond after that edge, before the next falling edge changes the inputs. The hold and reset checks read the registered pair after an edge at which in_vld was low or reset was high.

// File: rtl/modstep_unit.sv
module modstep_unit #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [1:0]   op,
  input  logic [W-1:0] cur_addr,
  input  logic [W-1:0] wrap,
  input  logic [W-1:0] step,
  output logic [W-1:0] nxt_addr,
  output logic [W-1:0] out_addr,
  output logic         out_vld
);
  localparam int XW = W + 2;
  localparam logic [W-1:0] IDX_MIN = {1'b1, {(W-1){1'b0}}};

  logic [XW-1:0] a, w, ix, mx, wp1;
  logic [XW-1:0] sum_add, sum_sub, sum_inc, sum_dec;
  logic [XW-1:0] cv_add, cv_sub, cv_inc, cv_dec;
  logic [XW-1:0] res;
  logic          neg_ix, sub_hi_branch;

  assign a       = {2'b00, cur_addr};
  assign w       = {2'b00, wrap};
  assign ix      = {{2{step[W-1]}}, step};
  assign mx      = {1'b0, wrap | {{(W-1){1'b0}}, 1'b1}, 1'b0};
  assign wp1     = w + 1'b1;
  assign neg_ix  = step[W-1];
  assign sub_hi_branch = neg_ix && (step != IDX_MIN);

  assign sum_add = a + ix;
  assign sum_sub = a - ix;
  assign sum_inc = a + 1'b1;
  assign sum_dec = a + w;

  assign cv_add  = (sum_add ^ a ^ ix) & mx;
  assign cv_sub  = (sum_sub ^ a ^ ~ix) & mx;
  assign cv_inc  = (sum_inc ^ a) & mx;
  assign cv_dec  = (sum_dec ^ a) & mx;

  function automatic logic [XW-1:0] fold_low(input logic [XW-1:0] s, input logic [XW-1:0] cv,
                                             input logic [XW-1:0] wv, input logic [XW-1:0] wv1);
    if ((((s + wv1) ^ s) & cv) <= wv) return s + wv1;
    return s;
  endfunction

  always_comb begin
    unique case (op)
      2'b00: res = neg_ix ? fold_low(sum_add, cv_add, w, wp1)
                          : ((cv_add > w) ? sum_add - wp1 : sum_add);
      2'b01: res = sub_hi_branch ? ((cv_sub > w) ? sum_sub - wp1 : sum_sub)
                                 : fold_low(sum_sub, cv_sub, w, wp1);
      2'b10: res = (cv_inc > w) ? sum_inc - wp1 : sum_inc;
      default: res = (cv_dec > w) ? sum_dec - wp1 : sum_dec;
    endcase
  end

  assign nxt_addr = res[W-1:0];

  AST_LINEAR_ADD: assert property (@(posedge clk) disable iff (rst) (wrap == '1 && op == 2'b00) |-> nxt_addr == W'(cur_addr + step)); // R7
  AST_LINEAR_SUB: assert property (@(posedge clk) disable iff (rst) (wrap == '1 && op == 2'b01) |-> nxt_addr == W'(cur_addr - step)); // R7
  AST_WINDOW: assert property (@(posedge clk) disable iff (rst) (op[1] && wrap != '0 && (wrap & W'(wrap + 1'b1)) == '0) |-> ((nxt_addr & ~wrap) == (cur_addr & ~wrap))); // R9

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_addr;
      logic         q_vld;
      always_ff @(posedge clk) begin
        if (rst) begin
          q_addr <= '0;
          q_vld  <= 1'b0;
        end else begin
          q_vld <= in_vld;
          if (in_vld) q_addr <= nxt_addr;
        end
      end
      assign out_addr = q_addr;
      assign out_vld  = q_vld;

      AST_OUT_DATA: assert property (@(posedge clk) disable iff (rst) in_vld |=> (out_vld && out_addr == $past(nxt_addr))); // R10
      AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !in_vld |=> (!out_vld && $stable(out_addr))); // R10
    end else begin : g_comb
      assign out_addr = nxt_addr;
      assign out_vld  = in_vld;
    end
  endgenerate
endmodule

// File: tb/sim_modstep_unit.sv
module sim_modstep_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] cur_addr = '0, wrap = '0, step = '0;
  logic [15:0] nxt_addr, out_addr;
  logic        out_vld;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  modstep_unit #(.W(16), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op(op), .cur_addr(cur_addr),
    .wrap(wrap), .step(step), .nxt_addr(nxt_addr), .out_addr(out_addr), .out_vld(out_vld));

  function automatic logic [15:0] ref_step(input logic [1:0] o, input logic [15:0] ar,
                                           input logic [15:0] wr, input logic [15:0] sx);
    logic [31:0] a, wv, x, m, n, d;
    a = {16'h0, ar}; wv = {16'h0, wr}; x = {{16{sx[15]}}, sx};
    m = (wv | 32'd1) << 1;
    case (o)
      2'b00: begin
        n = a + x; d = (n ^ a ^ x) & m;
        if (!sx[15]) begin if (d > wv) n = n - (wv + 1); end
        else if ((((n + wv + 1) ^ n) & d) <= wv) n = n + wv + 1;
      end
      2'b01: begin
        n = a - x; d = (n ^ a ^ ~x) & m;
        if (x > 32'hFFFF8000) begin if (d > wv) n = n - (wv + 1); end
        else if ((((n + wv + 1) ^ n) & d) <= wv) n = n + wv + 1;
      end
      2'b10: begin n = a + 1; if (((n ^ a) & m) > wv) n = n - (wv + 1); end
      default: begin n = a + wv; if (((n ^ a) & m) > wv) n = n - (wv + 1); end
    endcase
    return n[15:0];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] o, input logic [15:0] ar,
                       input logic [15:0] wr, input logic [15:0] sx, input logic [15:0] exp);
    @(negedge clk);
    op = o; cur_addr = ar; wrap = wr; step = sx; in_vld = 1'b1;
    #1 chk({tag, " comb"}, nxt_addr, exp);
    @(posedge clk);
    #1 chk({tag, " R10 reg"}, out_addr, exp);
    chk({tag, " R10 vld"}, {15'h0, out_vld}, 16'h1);
  endtask

  task automatic t_reset;
    repeat (2) @(posedge clk);
    #1 chk("R11 addr", out_addr, 16'h0);
    chk("R11 vld", {15'h0, out_vld}, 16'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_add;
    apply("R1 add wrap", 2'b00, 16'h001C, 16'h000F, 16'h0005, 16'h0011);
    apply("R1 add in", 2'b00, 16'h0012, 16'h000F, 16'h0002, 16'h0014);
    apply("R2 add neg", 2'b00, 16'h0012, 16'h000F, 16'hFFFB, 16'h001D);
    apply("R2 add neg in", 2'b00, 16'h001A, 16'h000F, 16'hFFFF, 16'h0019);
  endtask

  task automatic t_sub;
    apply("R3 sub neg", 2'b01, 16'h001D, 16'h000F, 16'hFFFC, 16'h0011);
    apply("R4 sub pos", 2'b01, 16'h0011, 16'h000F, 16'h0001, 16'h0010);
    apply("R4 sub min", 2'b01, 16'h0010, 16'h7FFF, 16'h8000, 16'h8010);
    apply("R4 sub max", 2'b01, 16'h0010, 16'hFFFF, 16'h7FFF, 16'h8011);
  endtask

  task automatic t_incdec;
    apply("R5 inc wrap", 2'b10, 16'h001F, 16'h000F, 16'h0000, 16'h0010);
    apply("R5 inc", 2'b10, 16'h0015, 16'h000F, 16'h0000, 16'h0016);
    apply("R6 dec wrap", 2'b11, 16'h0010, 16'h000F, 16'h0000, 16'h001F);
    apply("R6 dec", 2'b11, 16'h0015, 16'h000F, 16'h0000, 16'h0014);
    apply("R8 inc idx", 2'b10, 16'h0015, 16'h000F, 16'h7FFF, 16'h0016);
    apply("R8 dec idx", 2'b11, 16'h0015, 16'h000F, 16'h8000, 16'h0014);
    apply("R9 inc w1", 2'b10, 16'h0011, 16'h0001, 16'h0000, 16'h0010);
  endtask

  task automatic t_linear;
    apply("R7 add", 2'b00, 16'h9000, 16'hFFFF, 16'h7FFF, 16'h0FFF);
    apply("R7 sub", 2'b01, 16'h0000, 16'hFFFF, 16'h0001, 16'hFFFF);
    apply("R7 inc", 2'b10, 16'hFFFF, 16'hFFFF, 16'h1234, 16'h0000);
    apply("R7 dec", 2'b11, 16'h0000, 16'hFFFF, 16'h1234, 16'hFFFF);
  endtask

  task automatic t_hold;
    logic [15:0] kept;
    kept = out_addr;
    @(negedge clk);
    in_vld = 1'b0; op = 2'b00; cur_addr = 16'h4321; wrap = 16'hFFFF; step = 16'h0001;
    @(posedge clk);
    #1 chk("R10 hold addr", out_addr, kept);
    chk("R10 hold vld", {15'h0, out_vld}, 16'h0);
  endtask

  task automatic t_random;
    logic [15:0] corner [6] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'h7FFF, 16'h000F};
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  o;
      logic [15:0] ar, wr, sx;
      o  = 2'($urandom);
      ar = 16'($urandom);
      wr = (i % 3 == 0) ? corner[$urandom % 6] : 16'($urandom);
      sx = (i % 2 == 0) ? corner[$urandom % 6] : 16'($urandom);
      if (i % 5 == 0) sx = 16'hFFFF;
      case (o)
        2'b00: apply("R1 R2 rand add", o, ar, wr, sx, ref_step(o, ar, wr, sx));
        2'b01: apply("R3 R4 rand sub", o, ar, wr, sx, ref_step(o, ar, wr, sx));
        2'b10: apply("R5 rand inc", o, ar, wr, sx, ref_step(o, ar, wr, sx));
        default: apply("R6 rand dec", o, ar, wr, sx, ref_step(o, ar, wr, sx));
      endcase
    end
  endtask

  task automatic t_reset_mid;
    @(negedge clk); rst = 1'b1; in_vld = 1'b1;
    @(posedge clk);
    #1 chk("R11 mid addr", out_addr, 16'h0);
    chk("R11 mid vld", {15'h0, out_vld}, 16'h0);
    @(negedge clk); rst = 1'b0; in_vld = 1'b0;
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_incdec();
    t_linear();
    t_hold();
    t_random();
    t_reset_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule